// File: doc/BRIEF.md
# Accumulator ALU with Program Status Flags

This block is the byte-wide arithmetic and logic unit of an accumulator-based microcontroller core. On each accepted request it takes the accumulator, a second operand, the B register, an operation code and the incoming carry, auxiliary-carry and overflow flags. One clock later it returns a primary result byte, a secondary byte, the three updated flags and the even-parity bit of the primary result.

The operations are: add, add with carry, subtract with borrow, increment, decrement, AND, OR, XOR, clear, complement, rotate left and right (plain or through carry), nibble exchange, decimal adjust, 8x8 multiply, 8/8 divide, and the carry-only operations clear, set and invert. Each operation changes only the flags its own rule lists. The flags it leaves alone come out equal to the flags that went in, so the surrounding core can write all three back on every result. Operand fetch, addressing and instruction decode are handled in other blocks.

Top module: `alu8_psw`

## Requirements
- R1: A request with `in_valid`=1 gives its result on the outputs one clock later, with `out_valid`=1. When `in_valid`=0, `out_valid` is 0 on the next clock and all result outputs keep their values. Reset clears every output to 0.
- R2: `op_sel` codes: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 clear, 9 complement, 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 nibble swap, 15 decimal adjust, 16 multiply, 17 divide, 18 clear carry, 19 set carry, 20 invert carry.
- R3: Add (incoming carry ignored) and add-with-carry (carry added) return the 8-bit sum. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry into bit 7 XOR the carry out of bit 7.
- R4: Subtract-with-borrow returns A minus operand minus CY. CY is set on a borrow out of bit 7, AC on a borrow out of bit 3, and OV is the borrow into bit 7 XOR the borrow out of bit 7. Example: C9h, 54h, CY=1 gives 74h with CY=0, AC=0, OV=1.
- R5: Increment, decrement (both wrap), AND, OR, XOR, clear and complement leave CY, AC and OV unchanged.
- R6: Rotate left and rotate right cycle the 8 accumulator bits. Rotate left and right through carry cycle a 9-bit loop of A and CY, and change only CY among the flags. Nibble swap exchanges bits 7:4 with bits 3:0 and leaves all flags unchanged.
- R7: Decimal adjust adds 06h when the low nibble is above 9 or AC=1. It then adds 60h when the high nibble is above 9 or the carry so far is set. CY is set on either carry out and is never cleared. AC and OV are unchanged.
- R8: Multiply puts the low product byte on `res_a` and the high byte on `res_b`. CY=0, OV=1 exactly when the product exceeds FFh, and AC is unchanged.
- R9: Divide puts A/B on `res_a` and A mod B on `res_b`, with CY=0, OV=0 and AC unchanged. With B=0, OV=1, CY=0, `res_a`=FFh and `res_b`=A.
- R10: Clear carry, set carry and invert carry force CY to 0, force it to 1 and invert it. The result is A, and AC and OV are unchanged.
- R11: `par_out` is the XOR of all 8 bits of `res_a`, for every result.
- R12: For every code except multiply and divide, `res_b` equals `b_in`. Codes 21 to 31 return A with all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | B register operand |
| cy_in | input | 1 | Incoming carry |
| ac_in | input | 1 | Incoming auxiliary carry |
| ov_in | input | 1 | Incoming overflow |
| out_valid | output | 1 | Result strobe |
| res_a | output | 8 | Primary result (accumulator) |
| res_b | output | 8 | Secondary result (B register) |
| cy_out | output | 1 | Updated carry |
| ac_out | output | 1 | Updated auxiliary carry |
| ov_out | output | 1 | Updated overflow |
| par_out | output | 1 | Parity of res_a |

## Verification
Every cycle, the assertions check the one-cycle request-to-result timing and the hold behaviour while idle. They also check that multiply and divide clear CY and keep AC, that a zero divisor raises OV, and that decimal adjust never drops a set carry. They also cover the forced results of the carry-only operations, flag pass-through for the logical operations and parity against the primary result. Exact sums, borrow-derived flags, decimal-adjust corrections, product and quotient bytes, and rotate bit patterns depend on the operand values. Only the bench's directed scenarios with known answers can show these.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   parameter int unsigned ALU_W = 8;
   parameter int unsigned NIB_W = ALU_W / 2;
   parameter int unsigned OP_W  = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADDC = 5'd1,
      OP_SUBB = 5'd2,
      OP_INC  = 5'd3,
      OP_DEC  = 5'd4,
      OP_AND  = 5'd5,
      OP_OR   = 5'd6,
      OP_XOR  = 5'd7,
      OP_CLR  = 5'd8,
      OP_CPL  = 5'd9,
      OP_RL   = 5'd10,
      OP_RR   = 5'd11,
      OP_RLC  = 5'd12,
      OP_RRC  = 5'd13,
      OP_SWAP = 5'd14,
      OP_DA   = 5'd15,
      OP_MUL  = 5'd16,
      OP_DIV  = 5'd17,
      OP_CLRC = 5'd18,
      OP_SETC = 5'd19,
      OP_CPLC = 5'd20
   } alu_op_e;

   typedef struct packed {
      logic [ALU_W-1:0] lo;
      logic [ALU_W-1:0] hi;
      logic             cy;
      logic             ac;
      logic             ov;
   } alu_res_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
(
   input  logic [OP_W-1:0]  op,
   input  logic [ALU_W-1:0] a,
   input  logic [ALU_W-1:0] b,
   input  logic             cy,
   input  logic             ac,
   input  logic             ov,
   output alu_res_t         res
);
   localparam int unsigned W  = ALU_W;
   localparam int unsigned NB = NIB_W;

   logic [W:0]    cin_w;
   logic [NB:0]   cin_n;
   logic [W-1:0]  cin_7;
   logic [W:0]    full_s, full_d;
   logic [NB:0]   nib_s, nib_d;
   logic [W-1:0]  low7_s, low7_d;
   logic          use_c;

   // decimal adjust chain
   logic          adj_lo, adj_hi, c_mid;
   logic [W:0]    da_t1, da_t2;

   always_comb begin
      use_c  = (op == OP_ADDC) || (op == OP_SUBB) ? cy : 1'b0;
      cin_w  = {{W{1'b0}}, use_c};
      cin_n  = {{NB{1'b0}}, use_c};
      cin_7  = {{(W-1){1'b0}}, use_c};

      full_s = {1'b0, a} + {1'b0, b} + cin_w;
      nib_s  = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + cin_n;
      low7_s = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + cin_7;

      full_d = {1'b0, a} - {1'b0, b} - cin_w;
      nib_d  = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - cin_n;
      low7_d = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]} - cin_7;

      adj_lo = (a[NB-1:0] > 4'd9) || ac;
      da_t1  = {1'b0, a} + (adj_lo ? 9'h006 : 9'h000);
      c_mid  = cy | da_t1[W];
      adj_hi = (da_t1[W-1:NB] > 4'd9) || c_mid;
      da_t2  = {1'b0, da_t1[W-1:0]} + (adj_hi ? 9'h060 : 9'h000);

      res.lo = a;
      res.hi = '0;
      res.cy = cy;
      res.ac = ac;
      res.ov = ov;

      case (op)
         OP_ADD, OP_ADDC: begin
            res.lo = full_s[W-1:0];
            res.cy = full_s[W];
            res.ac = nib_s[NB];
            res.ov = low7_s[W-1] ^ full_s[W];
         end
         OP_SUBB: begin
            res.lo = full_d[W-1:0];
            res.cy = full_d[W];
            res.ac = nib_d[NB];
            res.ov = low7_d[W-1] ^ full_d[W];
         end
         OP_INC: res.lo = a + {{(W-1){1'b0}}, 1'b1};
         OP_DEC: res.lo = a - {{(W-1){1'b0}}, 1'b1};
         OP_DA: begin
            res.lo = da_t2[W-1:0];
            res.cy = c_mid | da_t2[W];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
(
   input  logic [OP_W-1:0]  op,
   input  logic [ALU_W-1:0] a,
   input  logic [ALU_W-1:0] b,
   input  logic             cy,
   input  logic             ac,
   input  logic             ov,
   output alu_res_t         res
);
   localparam int unsigned W  = ALU_W;
   localparam int unsigned NB = NIB_W;

   always_comb begin
      res.lo = a;
      res.hi = '0;
      res.cy = cy;
      res.ac = ac;
      res.ov = ov;
      case (op)
         OP_AND:  res.lo = a & b;
         OP_OR:   res.lo = a | b;
         OP_XOR:  res.lo = a ^ b;
         OP_CLR:  res.lo = '0;
         OP_CPL:  res.lo = ~a;
         OP_RL:   res.lo = {a[W-2:0], a[W-1]};
         OP_RR:   res.lo = {a[0], a[W-1:1]};
         OP_RLC: begin
            res.lo = {a[W-2:0], cy};
            res.cy = a[W-1];
         end
         OP_RRC: begin
            res.lo = {cy, a[W-1:1]};
            res.cy = a[0];
         end
         OP_SWAP: res.lo = {a[NB-1:0], a[W-1:NB]};
         OP_CLRC: res.cy = 1'b0;
         OP_SETC: res.cy = 1'b1;
         OP_CPLC: res.cy = ~cy;
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
   import alu8_pkg::*;
#(
   parameter bit MUL_OPERATOR = 1'b1,
   parameter bit DIV_OPERATOR = 1'b0
) (
   input  logic [ALU_W-1:0] a,
   input  logic [ALU_W-1:0] b,
   input  logic             is_div,
   output logic [ALU_W-1:0] lo,
   output logic [ALU_W-1:0] hi,
   output logic             ov
);
   localparam int unsigned W  = ALU_W;
   localparam int unsigned PW = 2 * W;

   logic [PW-1:0] prod;
   logic [W-1:0]  quo, rem;

   generate
      if (MUL_OPERATOR) begin : g_mul_op
         assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      end else begin : g_mul_shift
         logic [PW-1:0] part [0:W];
         assign part[0] = '0;
         for (genvar gi = 0; gi < W; gi++) begin : g_row
            assign part[gi+1] = part[gi] +
               (b[gi] ? ({{W{1'b0}}, a} << gi) : {PW{1'b0}});
         end
         assign prod = part[W];
      end

      if (DIV_OPERATOR) begin : g_div_op
         assign quo = (b == '0) ? {W{1'b1}} : a / b;
         assign rem = (b == '0) ? a : a % b;
      end else begin : g_div_restore
         logic [W:0] rchain [0:W];
         assign rchain[0] = '0;
         for (genvar gi = 0; gi < W; gi++) begin : g_step
            logic [W:0] shifted;
            assign shifted        = {rchain[gi][W-1:0], a[W-1-gi]};
            assign quo[W-1-gi]    = (shifted >= {1'b0, b});
            assign rchain[gi+1]   = quo[W-1-gi] ? (shifted - {1'b0, b}) : shifted;
         end
         assign rem = rchain[W][W-1:0];
      end
   endgenerate

   always_comb begin
      if (is_div) begin
         lo = quo;
         hi = rem;
         ov = (b == '0);
      end else begin
         lo = prod[W-1:0];
         hi = prod[PW-1:W];
         ov = |prod[PW-1:W];
      end
   end

endmodule

// File: rtl/alu8_psw.sv
module alu8_psw
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          MUL_OPERATOR = 1'b1,
   parameter bit          DIV_OPERATOR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              cy_in,
   input  logic              ac_in,
   input  logic              ov_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] res_a,
   output logic [DATA_W-1:0] res_b,
   output logic              cy_out,
   output logic              ac_out,
   output logic              ov_out,
   output logic              par_out
);
   generate
      if (DATA_W != ALU_W) begin : g_bad_width
         $error("alu8_psw: DATA_W must equal the package data width");
      end
      if (OP_W != 5) begin : g_bad_op
         $error("alu8_psw: operation code width must be 5");
      end
   endgenerate

   alu_res_t          arith_r, logic_r, nxt;
   logic [ALU_W-1:0]  md_lo, md_hi;
   logic              md_ov;
   logic              par_nxt;

   alu8_arith u_arith (
      .op (op_sel), .a (acc_in), .b (opnd_in),
      .cy (cy_in), .ac (ac_in), .ov (ov_in), .res (arith_r)
   );

   alu8_logic u_logic (
      .op (op_sel), .a (acc_in), .b (opnd_in),
      .cy (cy_in), .ac (ac_in), .ov (ov_in), .res (logic_r)
   );

   alu8_muldiv #(
      .MUL_OPERATOR (MUL_OPERATOR),
      .DIV_OPERATOR (DIV_OPERATOR)
   ) u_muldiv (
      .a (acc_in), .b (b_in), .is_div (op_sel == OP_DIV),
      .lo (md_lo), .hi (md_hi), .ov (md_ov)
   );

   always_comb begin
      nxt.lo = acc_in;
      nxt.hi = b_in;
      nxt.cy = cy_in;
      nxt.ac = ac_in;
      nxt.ov = ov_in;
      case (op_sel)
         OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC, OP_DA: begin
            nxt    = arith_r;
            nxt.hi = b_in;
         end
         OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_RL, OP_RR,
         OP_RLC, OP_RRC, OP_SWAP, OP_CLRC, OP_SETC, OP_CPLC: begin
            nxt    = logic_r;
            nxt.hi = b_in;
         end
         OP_MUL, OP_DIV: begin
            nxt.lo = md_lo;
            nxt.hi = md_hi;
            nxt.cy = 1'b0;
            nxt.ov = md_ov;
         end
         default: ;
      endcase
   end

   // parity as an explicit XOR chain over the result byte
   logic [ALU_W:0] pchain;
   assign pchain[0] = 1'b0;
   generate
      for (genvar gi = 0; gi < ALU_W; gi++) begin : g_par
         assign pchain[gi+1] = pchain[gi] ^ nxt.lo[gi];
      end
   endgenerate
   assign par_nxt = pchain[ALU_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_a     <= '0;
         res_b     <= '0;
         cy_out    <= 1'b0;
         ac_out    <= 1'b0;
         ov_out    <= 1'b0;
         par_out   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_a   <= nxt.lo;
            res_b   <= nxt.hi;
            cy_out  <= nxt.cy;
            ac_out  <= nxt.ac;
            ov_out  <= nxt.ov;
            par_out <= par_nxt;
         end
      end
   end

endmodule

// File: rtl/alu8_psw_chk.sv
module alu8_psw_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [4:0] op_sel,
   input logic [7:0] acc_in,
   input logic [7:0] b_in,
   input logic       cy_in,
   input logic       ac_in,
   input logic       ov_in,
   input logic       out_valid,
   input logic [7:0] res_a,
   input logic       cy_out,
   input logic       ac_out,
   input logic       ov_out,
   input logic       par_out
);
   logic is_md, is_bool;
   assign is_md   = (op_sel == 5'd16) || (op_sel == 5'd17);
   assign is_bool = (op_sel == 5'd5) || (op_sel == 5'd6) || (op_sel == 5'd7);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res_a) && $stable(cy_out))); // R1

   AST_BOOL_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_bool) |=>
      (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in))); // R5

   AST_DA_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 5'd15 && cy_in) |=> cy_out); // R7

   AST_DA_OV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 5'd15) |=> (ov_out == $past(ov_in))); // R7

   AST_MULDIV_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_md) |=> (!cy_out && ac_out == $past(ac_in))); // R8

   AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 5'd17 && b_in == 8'h00) |=> ov_out); // R9

   AST_SETC_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 5'd19) |=> (cy_out && res_a == $past(acc_in))); // R10

   AST_CLRC_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 5'd18) |=> !cy_out); // R10

   AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (par_out == ^res_a)); // R11

endmodule

bind alu8_psw alu8_psw_chk u_chk (.*);

// File: tb/alu8_psw_tb.sv
`timescale 1ns/1ps
module alu8_psw_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [4:0] op_sel = '0;
   logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
   logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
   logic       out_valid;
   logic [7:0] res_a, res_b;
   logic       cy_out, ac_out, ov_out, par_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alu8_psw dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_sel (op_sel),
      .acc_in (acc_in), .opnd_in (opnd_in), .b_in (b_in),
      .cy_in (cy_in), .ac_in (ac_in), .ov_in (ov_in),
      .out_valid (out_valid), .res_a (res_a), .res_b (res_b),
      .cy_out (cy_out), .ac_out (ac_out), .ov_out (ov_out), .par_out (par_out)
   );

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // drive one request, sample one clock later away from the edge
   task automatic run(string tag, logic [4:0] op, logic [7:0] a, logic [7:0] o,
                      logic [7:0] b, logic c, logic h, logic v,
                      logic [7:0] ea, logic [7:0] eb, logic ec, logic eh, logic ev);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; acc_in = a; opnd_in = o; b_in = b;
      cy_in = c; ac_in = h; ov_in = v;
      @(negedge clk);
      chk(tag, "valid", {7'd0, out_valid}, 8'd1);
      chk(tag, "res_a", res_a, ea);
      chk(tag, "res_b", res_b, eb);
      chk(tag, "cy",    {7'd0, cy_out}, {7'd0, ec});
      chk(tag, "ac",    {7'd0, ac_out}, {7'd0, eh});
      chk(tag, "ov",    {7'd0, ov_out}, {7'd0, ev});
      chk("R11", "parity", {7'd0, par_out}, {7'd0, ^ea});
   endtask

   task automatic t_reset();
      chk("R1", "reset valid", {7'd0, out_valid}, 8'd0);
      chk("R1", "reset res_a", res_a, 8'h00);
      chk("R1", "reset flags", {5'd0, cy_out, ac_out, ov_out}, 8'h00);
   endtask

   task automatic t_add();   // R3, codes per R2
      run("R3", 5'd0, 8'h7F, 8'h01, 8'h11, 1'b1, 1'b0, 1'b0, 8'h80, 8'h11, 1'b0, 1'b1, 1'b1);
      run("R3", 5'd0, 8'hFF, 8'h01, 8'h11, 1'b0, 1'b0, 1'b1, 8'h00, 8'h11, 1'b1, 1'b1, 1'b0);
      run("R3", 5'd1, 8'h80, 8'h7F, 8'h22, 1'b1, 1'b0, 1'b1, 8'h00, 8'h22, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_subb();
      run("R4", 5'd2, 8'hC9, 8'h54, 8'h00, 1'b1, 1'b1, 1'b0, 8'h74, 8'h00, 1'b0, 1'b0, 1'b1);
      run("R4", 5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_simple();
      run("R5", 5'd3, 8'hFF, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1);
      run("R5", 5'd4, 8'h00, 8'h00, 8'h33, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h33, 1'b0, 1'b1, 1'b0);
      run("R5", 5'd5, 8'hA5, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b1, 8'h24, 8'h00, 1'b1, 1'b0, 1'b1);
      run("R5", 5'd6, 8'hA5, 8'h3C, 8'h00, 1'b0, 1'b1, 1'b0, 8'hBD, 8'h00, 1'b0, 1'b1, 1'b0);
      run("R5", 5'd7, 8'hA5, 8'h3C, 8'h00, 1'b1, 1'b1, 1'b1, 8'h99, 8'h00, 1'b1, 1'b1, 1'b1);
      run("R5", 5'd8, 8'hA5, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      run("R5", 5'd9, 8'hA5, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_rotate();
      run("R6", 5'd10, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 8'h00, 1'b0, 1'b1, 1'b0);
      run("R6", 5'd11, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'hC0, 8'h00, 1'b0, 1'b0, 1'b0);
      run("R6", 5'd12, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h02, 8'h00, 1'b1, 1'b1, 1'b1);
      run("R6", 5'd13, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h40, 8'h00, 1'b1, 1'b0, 1'b0);
      run("R6", 5'd13, 8'h02, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0);
      run("R6", 5'd14, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_decadj();
      run("R7", 5'd15, 8'h7D, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h83, 8'h00, 1'b0, 1'b0, 1'b1);
      run("R7", 5'd15, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      run("R7", 5'd15, 8'h12, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h72, 8'h00, 1'b1, 1'b0, 1'b0);
      run("R7", 5'd15, 8'h05, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h0B, 8'h00, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_muldiv();
      run("R8", 5'd16, 8'h50, 8'h00, 8'hA0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h32, 1'b0, 1'b1, 1'b1);
      run("R8", 5'd16, 8'h0C, 8'h00, 8'h0B, 1'b1, 1'b0, 1'b1, 8'h84, 8'h00, 1'b0, 1'b0, 1'b0);
      run("R9", 5'd17, 8'hFB, 8'h00, 8'h12, 1'b1, 1'b1, 1'b1, 8'h0D, 8'h11, 1'b0, 1'b1, 1'b0);
      run("R9", 5'd17, 8'h37, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h37, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_carry_ops();
      run("R10", 5'd18, 8'h6E, 8'h00, 8'h44, 1'b1, 1'b1, 1'b0, 8'h6E, 8'h44, 1'b0, 1'b1, 1'b0);
      run("R10", 5'd19, 8'h6E, 8'h00, 8'h44, 1'b0, 1'b0, 1'b1, 8'h6E, 8'h44, 1'b1, 1'b0, 1'b1);
      run("R10", 5'd20, 8'h6F, 8'h00, 8'h44, 1'b1, 1'b0, 1'b0, 8'h6F, 8'h44, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_unused();
      run("R12", 5'd21, 8'h3C, 8'h99, 8'h5D, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h5D, 1'b1, 1'b0, 1'b1);
      run("R12", 5'd31, 8'hC3, 8'h99, 8'hE2, 1'b0, 1'b1, 1'b0, 8'hC3, 8'hE2, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_idle_hold();
      run("R1", 5'd0, 8'h10, 8'h20, 8'h01, 1'b0, 1'b0, 1'b0, 8'h30, 8'h01, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      in_valid = 1'b0; op_sel = 5'd9; acc_in = 8'hEE; b_in = 8'h77; cy_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle valid", {7'd0, out_valid}, 8'd0);
      chk("R1", "idle res_a", res_a, 8'h30);
      chk("R1", "idle res_b", res_b, 8'h01);
      chk("R1", "idle cy",    {7'd0, cy_out}, 8'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_add();
      t_subb();
      t_simple();
      t_rotate();
      t_decadj();
      t_muldiv();
      t_carry_ops();
      t_unused();
      t_idle_hold();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule